// File: doc/BRIEF.md
# Five-Pixel Delay-Line Hit Time Encoder

This block is the digital back end of a fine time measurement that five pixels share. Each pixel delivers a time-over-threshold pulse. The pulse is high while the pixel's discriminator sits above threshold. An arbiter takes the first pixel whose pulse rises and holds it until its pulse falls. While it is held, rising pulses from the other pixels are refused and counted.

On both edges of the granted pulse, the block latches two things: the 32 taps of an external delay-locked line, which spans one reference clock period, and a free-running 32-bit coarse counter. Each tap capture is a thermometer pattern. A bubble-tolerant encoder reduces it to a 5-bit fine code. Coarse and fine together form a 37-bit time in units of one delay bin.

After the falling edge is captured, the block presents one record. The record holds the pixel index, the leading-edge time, the trailing-edge time, their difference (the pulse width, used later for time-walk correction) and an error flag for unreadable tap codes. The pulses are taken as already synchronous to the reference clock. The edge decisions are made on clock samples.

Top module: `tot_hit_encoder`

## Requirements
- R1: After reset all outputs are zero. The coarse counter reads 0 in the first cycle after reset is released and advances by one on every clock edge. A captured coarse value is the counter value in the cycle before the capturing edge.
- R2: In the idle state, the first clock edge that samples a pulse high that was low at the previous edge grants that pixel and captures its leading time. If several pixels rise at the same edge, the lowest index wins. hitPixel reports the granted index, 0 to 4.
- R3: A rising pulse that is not granted is counted in lostCount. This covers rises while the arbiter is busy and the losing pixels of a tie. It has no effect on the record. lostCount holds at its maximum value.
- R4: The fine code of a tap capture is the highest position p at which the thermometer code holds ones at taps[p:0] and zeros above. All ones gives 31 and taps = 1 gives 0.
- R5: A single bubble is tolerated and gives the fine code of the clean pattern. A bubble is a lone 0 inside the run of ones, including at bit 0, or a lone 1 in the zero region.
- R6: An all-zero tap capture has no transition. It yields fine code 0 and sets hitCodeErr in the record that contains it.
- R7: The trailing time is captured at the first edge that samples the granted pulse low. hitValid is high for exactly one cycle, starting one clock edge after that capture.
- R8: Times are {coarse, fine}, that is coarse*32 + fine. hitWidth equals hitTrail minus hitLead modulo 2^37, including when the trailing fine code is below the leading one.
- R9: A rise sampled at the edge that raises hitValid is refused and counted as lost. A rise sampled at the next edge, while hitValid is high, is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixelPulse | input | 5 | Time-over-threshold pulses, one per pixel, synchronous to clk |
| taps | input | 32 | Delay-line tap states, thermometer code |
| hitValid | output | 1 | One-cycle strobe marking a new record |
| hitPixel | output | 3 | Index of the granted pixel |
| hitLead | output | 37 | Leading-edge time {coarse, fine} |
| hitTrail | output | 37 | Trailing-edge time {coarse, fine} |
| hitWidth | output | 37 | Trailing minus leading time, modulo 2^37 |
| hitCodeErr | output | 1 | Either tap capture of the record had no transition |
| lostCount | output | 16 | Saturating count of refused rising pulses |

## Verification
The hardest situation to reach is the one-cycle window around record output. In that window a second pixel's rise is refused at one edge and would be accepted at the next. The bench reaches it by counting negative edges from the moment it drops the granted pulse, and raising the second pixel exactly one edge apart in two separate runs. Bubble codes, the all-zero code and a trailing fine code below the leading one sit in the vector table. Ties and rises while busy are covered by directed sequences that track the lost count.

// File: rtl/tot_hit_pkg.sv
package tot_hit_pkg;
  typedef struct packed {
    logic captureLead;
    logic captureTrail;
    logic emit;
  } hit_strobe_t;
endpackage

// File: rtl/therm_fine_encoder.sv
module therm_fine_encoder #(
  parameter int TAPS = 32,
  localparam int FINE_W = $clog2(TAPS)
) (
  input  logic [TAPS-1:0]   taps,
  output logic [FINE_W-1:0] fine,
  output logic              noEdge
);
  // majority-of-three smoothing removes any single bubble
  logic [TAPS-1:0] smooth;

  for (genvar k = 0; k < TAPS; k++) begin : g_smooth
    logic below, above;
    if (k == 0) begin : g_lo
      assign below = 1'b1;
    end else begin : g_mid
      assign below = taps[k-1];
    end
    if (k == TAPS - 1) begin : g_hi
      assign above = 1'b0;
    end else begin : g_up
      assign above = taps[k+1];
    end
    assign smooth[k] = (below & taps[k]) | (below & above) | (taps[k] & above);
  end

  always_comb begin
    fine = '0;
    for (int k = 0; k < TAPS; k++) begin
      if (smooth[k]) fine = FINE_W'(k);
    end
  end

  assign noEdge = ~|smooth;
endmodule

// File: rtl/tot_hit_ctrl.sv
module tot_hit_ctrl
  import tot_hit_pkg::*;
#(
  parameter int NUM_PIX = 5,
  parameter int LOST_W = 16,
  localparam int IDX_W = $clog2(NUM_PIX),
  localparam int CNT_W = $clog2(NUM_PIX + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_PIX-1:0] pixelPulse,
  output hit_strobe_t        strobe,
  output logic [IDX_W-1:0]   grantIdx,
  output logic [LOST_W-1:0]  lostCount
);
  typedef enum logic [1:0] {ARB_IDLE, ARB_BUSY, ARB_EMIT} arb_state_t;

  arb_state_t state, stateNext;
  logic [NUM_PIX-1:0] pulseD, rise;
  logic [IDX_W-1:0] firstIdx;
  logic [CNT_W-1:0] nRise, lostInc;
  logic [LOST_W:0] lostSum;
  logic grantFell;

  assign rise = pixelPulse & ~pulseD;
  assign grantFell = pulseD[grantIdx] & ~pixelPulse[grantIdx];

  always_comb begin
    firstIdx = '0;
    nRise = '0;
    for (int i = NUM_PIX - 1; i >= 0; i--) begin
      if (rise[i]) firstIdx = IDX_W'(i);
    end
    for (int i = 0; i < NUM_PIX; i++) begin
      nRise = nRise + CNT_W'(rise[i]);
    end
  end

  always_comb begin
    stateNext = state;
    strobe = '0;
    lostInc = nRise;
    case (state)
      ARB_IDLE: begin
        if (|rise) begin
          strobe.captureLead = 1'b1;
          lostInc = nRise - CNT_W'(1);
          stateNext = ARB_BUSY;
        end
      end
      ARB_BUSY: begin
        if (grantFell) begin
          strobe.captureTrail = 1'b1;
          stateNext = ARB_EMIT;
        end
      end
      default: begin
        strobe.emit = 1'b1;
        stateNext = ARB_IDLE;
      end
    endcase
  end

  assign lostSum = {1'b0, lostCount} + (LOST_W + 1)'(lostInc);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ARB_IDLE;
      pulseD <= '0;
      grantIdx <= '0;
      lostCount <= '0;
    end else begin
      state <= stateNext;
      pulseD <= pixelPulse;
      if (strobe.captureLead) grantIdx <= firstIdx;
      lostCount <= lostSum[LOST_W] ? '1 : lostSum[LOST_W-1:0];
    end
  end
endmodule

// File: rtl/tot_hit_datapath.sv
module tot_hit_datapath
  import tot_hit_pkg::*;
#(
  parameter int NUM_PIX = 5,
  parameter int TAPS = 32,
  parameter int COARSE_W = 32,
  localparam int IDX_W = $clog2(NUM_PIX),
  localparam int FINE_W = $clog2(TAPS),
  localparam int TIME_W = COARSE_W + FINE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TAPS-1:0]   taps,
  input  hit_strobe_t       strobe,
  input  logic [IDX_W-1:0]  grantIdx,
  output logic              hitValid,
  output logic [IDX_W-1:0]  hitPixel,
  output logic [TIME_W-1:0] hitLead,
  output logic [TIME_W-1:0] hitTrail,
  output logic [TIME_W-1:0] hitWidth,
  output logic              hitCodeErr
);
  logic [COARSE_W-1:0] coarseCnt;
  logic [FINE_W-1:0] fineNow;
  logic fineBad;
  logic [TIME_W-1:0] leadTime, trailTime;
  logic leadErr, trailErr;

  therm_fine_encoder #(.TAPS(TAPS)) u_enc (
    .taps(taps),
    .fine(fineNow),
    .noEdge(fineBad)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      coarseCnt <= '0;
      leadTime <= '0;
      trailTime <= '0;
      leadErr <= 1'b0;
      trailErr <= 1'b0;
      hitValid <= 1'b0;
      hitPixel <= '0;
      hitLead <= '0;
      hitTrail <= '0;
      hitWidth <= '0;
      hitCodeErr <= 1'b0;
    end else begin
      coarseCnt <= coarseCnt + COARSE_W'(1);
      hitValid <= strobe.emit;
      if (strobe.captureLead) begin
        leadTime <= {coarseCnt, fineNow};
        leadErr <= fineBad;
      end
      if (strobe.captureTrail) begin
        trailTime <= {coarseCnt, fineNow};
        trailErr <= fineBad;
      end
      if (strobe.emit) begin
        hitPixel <= grantIdx;
        hitLead <= leadTime;
        hitTrail <= trailTime;
        hitWidth <= trailTime - leadTime;
        hitCodeErr <= leadErr | trailErr;
      end
    end
  end
endmodule

// File: rtl/tot_hit_encoder.sv
module tot_hit_encoder
  import tot_hit_pkg::*;
#(
  parameter int NUM_PIX = 5,
  parameter int TAPS = 32,
  parameter int COARSE_W = 32,
  parameter int LOST_W = 16,
  localparam int IDX_W = $clog2(NUM_PIX),
  localparam int TIME_W = COARSE_W + $clog2(TAPS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_PIX-1:0] pixelPulse,
  input  logic [TAPS-1:0]    taps,
  output logic               hitValid,
  output logic [IDX_W-1:0]   hitPixel,
  output logic [TIME_W-1:0]  hitLead,
  output logic [TIME_W-1:0]  hitTrail,
  output logic [TIME_W-1:0]  hitWidth,
  output logic               hitCodeErr,
  output logic [LOST_W-1:0]  lostCount
);
  hit_strobe_t strobe;
  logic [IDX_W-1:0] grantIdx;

  tot_hit_ctrl #(.NUM_PIX(NUM_PIX), .LOST_W(LOST_W)) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .pixelPulse(pixelPulse),
    .strobe(strobe),
    .grantIdx(grantIdx),
    .lostCount(lostCount)
  );

  tot_hit_datapath #(.NUM_PIX(NUM_PIX), .TAPS(TAPS), .COARSE_W(COARSE_W)) u_dp (
    .clk(clk),
    .rstN(rstN),
    .taps(taps),
    .strobe(strobe),
    .grantIdx(grantIdx),
    .hitValid(hitValid),
    .hitPixel(hitPixel),
    .hitLead(hitLead),
    .hitTrail(hitTrail),
    .hitWidth(hitWidth),
    .hitCodeErr(hitCodeErr)
  );
endmodule

// File: rtl/tot_hit_encoder_checker.sv
module tot_hit_encoder_checker #(
  parameter int NUM_PIX = 5,
  parameter int LOST_W = 16,
  localparam int IDX_W = $clog2(NUM_PIX)
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_PIX-1:0] pixelPulse,
  input logic               hitValid,
  input logic [IDX_W-1:0]   hitPixel,
  input logic [LOST_W-1:0]  lostCount
);
  logic [NUM_PIX-1:0] pulseH1, pulseH2;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulseH1 <= '0;
      pulseH2 <= '0;
    end else begin
      pulseH1 <= pixelPulse;
      pulseH2 <= pulseH1;
    end
  end

  assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    hitValid |=> !hitValid);

  assert_pixel_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    hitValid |-> (int'(hitPixel) < NUM_PIX));

  assert_lost_monotonic_R3: assert property (@(posedge clk) disable iff (!rstN)
    lostCount >= $past(lostCount));

  // the granted pulse was sampled low at the edge two before the record is seen
  assert_trail_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    hitValid |-> !pulseH2[hitPixel]);
endmodule

bind tot_hit_encoder tot_hit_encoder_checker #(.NUM_PIX(NUM_PIX), .LOST_W(LOST_W)) u_chk (
  .clk(clk),
  .rstN(rstN),
  .pixelPulse(pixelPulse),
  .hitValid(hitValid),
  .hitPixel(hitPixel),
  .lostCount(lostCount)
);

// File: tb/tb_tot_hit_encoder.sv
module tb_tot_hit_encoder;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] pixelPulse = '0;
  logic [31:0] taps = '0;
  logic hitValid;
  logic [2:0] hitPixel;
  logic [36:0] hitLead, hitTrail, hitWidth;
  logic hitCodeErr;
  logic [15:0] lostCount;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [31:0] benchCnt;
  int expLost = 0;

  always #4 clk = ~clk;

  tot_hit_encoder dut (
    .clk(clk), .rstN(rstN), .pixelPulse(pixelPulse), .taps(taps),
    .hitValid(hitValid), .hitPixel(hitPixel), .hitLead(hitLead),
    .hitTrail(hitTrail), .hitWidth(hitWidth), .hitCodeErr(hitCodeErr),
    .lostCount(lostCount)
  );

  // coarse count per R1: zero in the first cycle after reset, one per edge after
  always @(posedge clk) begin
    if (!rstN) benchCnt <= '0;
    else benchCnt <= benchCnt + 32'd1;
  end

  typedef struct packed {
    logic [2:0]  pix;
    logic [31:0] tLead;
    logic [31:0] tTrail;
    logic [7:0]  dur;
    logic [4:0]  fLead;
    logic [4:0]  fTrail;
    logic        err;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{3'd0, 32'h0000_00FF, 32'h001F_FFFF, 8'd3,  5'd7,  5'd20, 1'b0},
    '{3'd4, 32'h7FFF_FFFF, 32'h0000_0007, 8'd5,  5'd30, 5'd2,  1'b0},
    '{3'd2, 32'hFFFF_FFFF, 32'h0000_0001, 8'd1,  5'd31, 5'd0,  1'b0},
    '{3'd1, 32'h001F_FBFF, 32'h1000_003F, 8'd4,  5'd20, 5'd5,  1'b0},
    '{3'd3, 32'h0000_0000, 32'h0000_1FFF, 8'd2,  5'd0,  5'd12, 1'b1},
    '{3'd0, 32'h0000_FFFF, 32'h0000_03FE, 8'd40, 5'd15, 5'd9,  1'b0}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic checkRecord(input string tag, input logic [2:0] pix,
                             input logic [36:0] lead, input logic [36:0] trail,
                             input logic err);
    logic [36:0] w;
    w = trail - lead;
    check({"R7 valid ", tag}, 64'(hitValid), 64'd1);
    check({"R2 pixel ", tag}, 64'(hitPixel), 64'(pix));
    check({"R1 R4 R5 lead ", tag}, 64'(hitLead), 64'(lead));
    check({"R7 trail ", tag}, 64'(hitTrail), 64'(trail));
    check({"R8 width ", tag}, 64'(hitWidth), 64'(w));
    check({"R6 error flag ", tag}, 64'(hitCodeErr), 64'(err));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] c1, c2;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 reset valid", 64'(hitValid), 64'd0);
    check("R1 reset lead", 64'(hitLead), 64'd0);
    check("R1 reset width", 64'(hitWidth), 64'd0);
    check("R1 reset lost", 64'(lostCount), 64'd0);

    // table of single hits
    for (int v = 0; v < 6; v++) begin
      @(negedge clk);
      taps = VECS[v].tLead;
      pixelPulse[VECS[v].pix] = 1'b1;
      c1 = benchCnt;
      repeat (int'(VECS[v].dur)) @(negedge clk);
      taps = VECS[v].tTrail;
      pixelPulse[VECS[v].pix] = 1'b0;
      c2 = benchCnt;
      @(negedge clk);
      check("R7 no early valid", 64'(hitValid), 64'd0);
      @(negedge clk);
      checkRecord($sformatf("vec%0d", v), VECS[v].pix, {c1, VECS[v].fLead},
                  {c2, VECS[v].fTrail}, VECS[v].err);
      @(negedge clk);
      check("R7 valid one cycle", 64'(hitValid), 64'd0);
    end

    // R3 tie: pixels 2 and 4 rise together, lowest index wins
    @(negedge clk);
    taps = 32'h0000_003F;
    pixelPulse = 5'b10100;
    c1 = benchCnt;
    expLost++;
    repeat (2) @(negedge clk);
    pixelPulse = 5'b00000;
    c2 = benchCnt;
    repeat (2) @(negedge clk);
    checkRecord("tie", 3'd2, {c1, 5'd5}, {c2, 5'd5}, 1'b0);
    check("R3 tie lost", 64'(lostCount), 64'(expLost));

    // R3 busy: pixel 3 rises while pixel 0 is granted, then falls first
    @(negedge clk);
    taps = 32'h0000_0FFF;
    pixelPulse[0] = 1'b1;
    c1 = benchCnt;
    repeat (2) @(negedge clk);
    pixelPulse[3] = 1'b1;
    expLost++;
    repeat (2) @(negedge clk);
    pixelPulse[3] = 1'b0;
    @(negedge clk);
    check("R3 busy refused no record", 64'(hitValid), 64'd0);
    taps = 32'h00FF_FFFF;
    pixelPulse[0] = 1'b0;
    c2 = benchCnt;
    repeat (2) @(negedge clk);
    checkRecord("busy", 3'd0, {c1, 5'd11}, {c2, 5'd23}, 1'b0);
    check("R3 busy lost", 64'(lostCount), 64'(expLost));

    // R9 rise sampled at the edge that raises hitValid is refused
    @(negedge clk);
    taps = 32'h0000_0003;
    pixelPulse[1] = 1'b1;
    repeat (3) @(negedge clk);
    pixelPulse[1] = 1'b0;
    @(negedge clk);
    pixelPulse[2] = 1'b1;
    expLost++;
    @(negedge clk);
    check("R9 record of pixel 1", 64'(hitPixel), 64'd1);
    repeat (3) @(negedge clk);
    pixelPulse[2] = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 refused rise gives no record", 64'(hitValid), 64'd0);
    check("R9 refused rise counted", 64'(lostCount), 64'(expLost));

    // R9 rise sampled while hitValid is high is granted
    @(negedge clk);
    pixelPulse[1] = 1'b1;
    repeat (2) @(negedge clk);
    pixelPulse[1] = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 valid before re-arm", 64'(hitValid), 64'd1);
    taps = 32'h0003_FFFF;
    pixelPulse[3] = 1'b1;
    c1 = benchCnt;
    repeat (2) @(negedge clk);
    taps = 32'h0000_0001;
    pixelPulse[3] = 1'b0;
    c2 = benchCnt;
    repeat (2) @(negedge clk);
    checkRecord("rearm", 3'd3, {c1, 5'd17}, {c2, 5'd0}, 1'b0);
    check("R9 rearm lost unchanged", 64'(lostCount), 64'(expLost));

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule